// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block owns a bit-per-slot command-issued register. Software marks a slot as ready by writing a 1 to its bit through a simple write port. The register is write-1-to-set: a 0 in the written data leaves the bit alone, and software has no way to clear a bit. The live register value is always available on a read output.

The block decides which pending slot goes to the device next. It tracks how old each pending bit is, measured by the write that set it. The oldest slot is offered first on a valid/ready issue handshake. When several slots were set by one write, the lowest index wins.

Only non-queued commands are handled, so one slot at most is in flight. The next offer waits until the device reports completion for the in-flight slot, and that completion clears the slot's bit. Dropping the start control clears the whole register and abandons any command in flight.

Top module: `cis_sched`

## Requirements
- R1: After reset, `rd_value` is 0 and `iss_valid` is 0.
- R2: Bit n of the register stands for slot n. A write with `wr_en`=1 while `start`=1 sets every bit that has a 1 in `wr_data`, and the new value appears on `rd_value` in the cycle after the write. Bits written with 0 keep their value.
- R3: A write made while `start`=0 changes no bit of the register, and no issue is offered while `start`=0.
- R4: On the clock edge where `start` is sampled 0 after being 1, every bit clears, and `rd_value` reads 0 from the next cycle on. Any in-flight slot is abandoned, so a slot set after `start` returns to 1 is offered.
- R5: The slot offered on `iss_slot` is the pending slot set by the earliest write. Writing 1 again to a bit that is already set does not change its age.
- R6: Among pending slots set by the same write, the lowest slot index is offered first.
- R7: After a transfer (`iss_valid` and `iss_ready` both 1 on a clock edge), `iss_valid` stays 0 until the completion for that slot has been taken.
- R8: A completion (`cpl_valid`=1 with `cpl_slot` equal to the in-flight slot) clears that slot's bit on the same edge. A completion for any other slot, or one that arrives while nothing is in flight, changes nothing.
- R9: While `iss_valid` is 1 and `iss_ready` is 0, `iss_valid` stays 1 and `iss_slot` stays stable, even when younger slots are set, as long as `start` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Start control: enables setting bits; a 1-to-0 change clears the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | NSLOT | Write data; each 1 bit sets the bit for that slot |
| rd_value | output | NSLOT | Live value of the command-issued register |
| iss_valid | output | 1 | A slot is offered to the device |
| iss_ready | input | 1 | The device accepts the offered slot |
| iss_slot | output | IW | Index of the offered slot |
| cpl_valid | input | 1 | Completion indication: the device reports busy, data request and error all clear |
| cpl_slot | input | IW | Slot index the completion refers to |

## Verification
The bench uses the default of 32 slots and a 5-bit index. With this setting, the top slot 31 and the full index width both sit in the age ordering next to slots 0 and 2. It also makes a four-bit single write possible, which shows the lowest-index tie-break across slots 4 to 7.

A scripted completion responder can be switched off. With it off, a slot can be held in flight, so the bench can check completions that must be ignored, the hold-off of further offers, and abandonment when `start` drops.

// File: rtl/cis_pkg.sv
package cis_pkg;

  typedef enum logic {
    ISS_IDLE = 1'b0,
    ISS_BUSY = 1'b1
  } iss_state_e;

endpackage

// File: rtl/cis_rst_sync.sv
module cis_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/cis_age_matrix.sv
module cis_age_matrix #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] set_mask,
  input  logic [NSLOT-1:0] clr_mask,
  input  logic             clr_all,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] oldest
);

  // older_q[i][j] = 1 : slot i was set by an earlier write than slot j
  logic [NSLOT-1:0] older_q [NSLOT];
  logic [NSLOT-1:0] older_d [NSLOT];
  logic [NSLOT-1:0] pend_q;
  logic [NSLOT-1:0] pend_d;
  logic [NSLOT-1:0] keep;
  logic             upd_en;

  always_comb begin
    keep   = pend_q & ~clr_mask;
    pend_d = clr_all ? '0 : (keep | set_mask);
    upd_en = clr_all | (|set_mask) | (|clr_mask);
    for (int i = 0; i < NSLOT; i++) begin
      for (int j = 0; j < NSLOT; j++) begin
        if (set_mask[i]) begin
          older_d[i][j] = 1'b0;
        end else if (set_mask[j]) begin
          older_d[i][j] = keep[i];
        end else begin
          older_d[i][j] = older_q[i][j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        older_q[i] <= '0;
      end
    end else if (upd_en) begin
      pend_q <= pend_d;
      for (int i = 0; i < NSLOT; i++) begin
        older_q[i] <= older_d[i];
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_col
    logic [NSLOT-1:0] col;
    always_comb begin
      for (int j = 0; j < NSLOT; j++) begin
        col[j] = older_q[j][g];
      end
    end
    assign oldest[g] = pend_q[g] & ~(|(col & pend_q));
  end

  assign pend = pend_q;

  // R8: a bit only drops through a completion mask or a full clear
  assert_clear_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) || ((($past(pend_q) & ~pend_q) & ~$past(clr_mask)) == '0));

  // R5: the age order never forms a cycle, so something pending is always oldest
  assert_oldest_exists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_q) |-> (|oldest));

endmodule

// File: rtl/cis_pick_low.sv
module cis_pick_low #(
  parameter int NSLOT = 32,
  parameter int IW    = 5
) (
  input  logic [NSLOT-1:0] mask,
  output logic [IW-1:0]    idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = IW'(i);
      end
    end
  end

  assign any = |mask;

  // R6: the chosen index is one of the candidates
  always_comb begin
    if (any) begin
      assert_pick_member_R6: assert (mask[idx]);
    end
  end

endmodule

// File: rtl/cis_sched.sv
module cis_sched
  import cis_pkg::*;
#(
  parameter  int NSLOT = 32,
  localparam int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_en,
  input  logic [NSLOT-1:0] wr_data,
  output logic [NSLOT-1:0] rd_value,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [IW-1:0]    iss_slot,
  input  logic             cpl_valid,
  input  logic [IW-1:0]    cpl_slot
);

  localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};

  logic             rst_sync_n;
  logic             start_q;
  logic             start_fall;
  logic [NSLOT-1:0] pend;
  logic [NSLOT-1:0] oldest;
  logic [NSLOT-1:0] set_mask;
  logic [NSLOT-1:0] clr_mask;
  logic [IW-1:0]    pick_idx;
  logic             pick_any;
  iss_state_e       state_q, state_d;
  logic [IW-1:0]    slot_q, slot_d;
  logic             ctrl_en;
  logic             xfer;
  logic             cpl_hit;

  cis_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign start_fall = start_q & ~start;
  assign set_mask   = (wr_en && start) ? (wr_data & ~pend) : '0;
  assign cpl_hit    = cpl_valid && (state_q == ISS_BUSY) && (cpl_slot == slot_q);
  assign clr_mask   = cpl_hit ? (ONE << slot_q) : '0;

  cis_age_matrix #(.NSLOT(NSLOT)) u_age (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .clr_all  (start_fall),
    .pend     (pend),
    .oldest   (oldest)
  );

  cis_pick_low #(.NSLOT(NSLOT), .IW(IW)) u_pick (
    .mask (oldest),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  assign iss_valid = start && (state_q == ISS_IDLE) && pick_any;
  assign iss_slot  = pick_idx;
  assign xfer      = iss_valid && iss_ready;
  assign rd_value  = pend;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    if (start_fall) begin
      state_d = ISS_IDLE;
    end else if (state_q == ISS_BUSY) begin
      if (cpl_hit) begin
        state_d = ISS_IDLE;
      end
    end else if (xfer) begin
      state_d = ISS_BUSY;
      slot_d  = pick_idx;
    end
    ctrl_en = start_fall | cpl_hit | xfer;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ISS_IDLE;
      slot_q  <= '0;
    end else if (ctrl_en) begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start;
    end
  end

  // R4: a falling start empties the register
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(start) |=> (rd_value == '0));

  // R3: no bit is newly set by a write while stopped
  assert_no_set_stopped_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> ((rd_value & ~$past(rd_value)) == '0));

  // R7: a transfer blocks further offers in the next cycle
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer |=> !iss_valid);

  // R9: an unaccepted offer holds its slot
  assert_offer_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iss_valid && !iss_ready) |=> (!start || (iss_valid && $stable(iss_slot))));

  // R2: only a pending slot is offered
  assert_offer_pending_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    iss_valid |-> rd_value[iss_slot]);

endmodule

// File: tb/cis_sched_bench.sv
module cis_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 32;
  localparam int IW         = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             wr_en;
  logic [NSLOT-1:0] wr_data;
  logic [NSLOT-1:0] rd_value;
  logic             iss_valid;
  logic             iss_ready;
  logic [IW-1:0]    iss_slot;
  logic             cpl_valid;
  logic [IW-1:0]    cpl_slot;

  logic             auto_v = 1'b0;
  logic [IW-1:0]    auto_s = '0;
  logic             inj_v;
  logic [IW-1:0]    inj_s;
  bit               auto_en;
  bit               mon_busy = 1'b0;
  int               cpl_wait = 0;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];

  assign cpl_valid = auto_v | inj_v;
  assign cpl_slot  = auto_v ? auto_s : inj_s;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cis_sched #(.NSLOT(NSLOT)) u_cis_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_value  (rd_value),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_slot  (iss_slot),
    .cpl_valid (cpl_valid),
    .cpl_slot  (cpl_slot)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_issue(input int slot, input string req);
    exp_q.push_back(slot);
    tag_q.push_back(req);
  endtask

  task automatic wr(input logic [NSLOT-1:0] d);
    @(posedge clk); #1;
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk); #1;
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic inject(input logic [IW-1:0] s);
    @(posedge clk); #1;
    inj_v = 1'b1;
    inj_s = s;
    @(posedge clk); #1;
    inj_v = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !mon_busy && rd_value == '0) break;
    end
    chk(exp_q.size() == 0, req, "expected issues left", exp_q.size(), 0);
    chk(rd_value == '0, req, "register after completions", rd_value, 0);
  endtask

  // Monitor and completion responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (!start) mon_busy = 1'b0;
      if (auto_v) begin
        auto_v   = 1'b0;
        mon_busy = 1'b0;
      end
      if (mon_busy) begin
        chk(!iss_valid, "R7", "offer while in flight", iss_valid, 0);
        if (auto_en) begin
          if (cpl_wait == 0) begin
            auto_v = 1'b1;
          end else begin
            cpl_wait--;
          end
        end
      end else if (iss_valid && iss_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected issue slot", iss_slot, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(iss_slot == IW'(e), t, "issue order", iss_slot, e);
        end
        mon_busy = 1'b1;
        auto_s   = iss_slot;
        cpl_wait = 2;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_data = '0;
    iss_ready = 1'b0; inj_v = 1'b0; inj_s = '0; auto_en = 1'b1;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rd_value == '0, "R1", "register after reset", rd_value, 0);
    chk(!iss_valid, "R1", "offer after reset", iss_valid, 0);

    // R2 / R5: separate writes build an age order, a rewrite keeps age
    @(posedge clk); #1; start = 1'b1;
    wr(32'h0000_0010);
    wr(32'h0000_0005);
    wr(32'h8000_0000);
    wr(32'h0000_0010);
    settle();
    chk(rd_value == 32'h8000_0015, "R2", "register after sets", rd_value, 32'h8000_0015);
    wr(32'h0000_0000);
    settle();
    chk(rd_value == 32'h8000_0015, "R2", "zero write", rd_value, 32'h8000_0015);
    chk(iss_valid && iss_slot == 5'd4, "R5", "oldest offered", iss_slot, 4);
    expect_issue(4, "R5");
    expect_issue(0, "R6");
    expect_issue(2, "R6");
    expect_issue(31, "R5");
    @(posedge clk); #1; iss_ready = 1'b1;
    drain("R8");

    // R6: one write, lowest index first
    expect_issue(4, "R6");
    expect_issue(5, "R6");
    expect_issue(6, "R6");
    expect_issue(7, "R6");
    wr(32'h0000_00F0);
    drain("R6");

    // R9 hold, R8 stray completion while idle
    @(posedge clk); #1; iss_ready = 1'b0;
    wr(32'h0000_0200);
    wr(32'h0000_0008);
    settle();
    chk(iss_valid && iss_slot == 5'd9, "R9", "held offer", iss_slot, 9);
    wr(32'h0000_0002);
    inject(5'd3);
    settle();
    chk(rd_value == 32'h0000_020A, "R8", "stray completion idle", rd_value, 32'h20A);
    chk(iss_valid && iss_slot == 5'd9, "R9", "offer stable", iss_slot, 9);
    expect_issue(9, "R5");
    expect_issue(3, "R5");
    expect_issue(1, "R5");
    @(posedge clk); #1; iss_ready = 1'b1;
    drain("R5");

    // R7 / R8 / R4 / R3 with responder off
    auto_en = 1'b0;
    expect_issue(0, "R7");
    wr(32'h0000_0003);
    repeat (6) @(negedge clk);
    chk(rd_value == 32'h3, "R7", "slots pending while in flight", rd_value, 3);
    chk(!iss_valid, "R7", "no second offer", iss_valid, 0);
    inject(5'd1);
    settle();
    chk(rd_value == 32'h3, "R8", "completion for other slot", rd_value, 3);
    @(posedge clk); #1; start = 1'b0;
    settle();
    chk(rd_value == '0, "R4", "clear on stop", rd_value, 0);
    wr(32'h0000_00FF);
    settle();
    chk(rd_value == '0, "R3", "write while stopped", rd_value, 0);
    chk(!iss_valid, "R3", "offer while stopped", iss_valid, 0);
    auto_en = 1'b1;
    @(posedge clk); #1; start = 1'b1;
    expect_issue(2, "R4");
    wr(32'h0000_0004);
    drain("R4");

    finish_run();
  end

endmodule